// File: doc/BRIEF.md
# Power-on strap sampling controller

This block manages a package pin that serves two roles over time. At power-up the pin is an input: the output driver is held three-stated so that an external pull resistor (to ground or to the supply) sets its level. Once a supply-good indication asserts, the block counts a fixed window of reference-clock cycles. At the end of that window it captures the pin level into a sticky configuration register. One cycle later it enables the driver so the pin carries a forwarded clock from then on.

The captured bit on the shared pin chooses the width of the spread modulation. A separate active-low control input decides whether spreading is requested at all. The captured value survives everything except removal of the supply, which the block sees as supply-good falling. Supply-good is the only reset. There is no streaming data path, so no valid/ready handshake or back-pressure exists. All pins are plain level control and status.

Top module: `strap_pin_sequencer`

## Requirements
- R1: After `supply_good` rises, `cfg_valid` stays low for the first WINDOW_CYCLES-1 rising edges of `clk_ref` and is high after edge WINDOW_CYCLES. The default WINDOW_CYCLES is 28636, which is about 2 ms at 14.318 MHz.
- R2: `pad_oe` is low (driver three-stated) on every bit while `cfg_valid` is low.
- R3: `cfg_bits[i]` takes the level of `pin_in[i]` as it stood before the final window edge, after two synchronizer flops. A low level is read as 0 and a high level as 1.
- R4: `pad_oe` rises on every bit exactly one `clk_ref` edge after `cfg_valid` rises, and then stays high.
- R5: `pad_do` stays low while `pad_oe` is low. After `pad_oe` rises, the forwarded clock is only released at a falling edge of `src_clk`, so if `src_clk` is high when the driver turns on, `pad_do` stays low until the next low phase.
- R6: Once valid, `cfg_bits` and `cfg_valid` hold, and later changes on `pin_in` have no effect.
- R7: When `supply_good` is low, the block asynchronously clears `cfg_valid`, `cfg_bits`, `pad_oe` and `pad_do`. The window restarts from zero when the supply returns.
- R8: `spread_on` is high only when `cfg_valid` is high and `spread_ctl_n` is low. `spread_wide` presents `cfg_bits[WIDTH_SEL_BIT]` (default bit 0), with 1 selecting the wider modulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the window |
| supply_good | input | 1 | High when the supply is above threshold; low acts as the reset |
| pin_in | input | NUM_STRAPS | Level read back from the dual-purpose pins |
| src_clk | input | 1 | Clock to forward onto the pins |
| spread_ctl_n | input | 1 | Active-low request for spreading |
| pad_oe | output | NUM_STRAPS | Output-driver enable per pin |
| pad_do | output | NUM_STRAPS | Output data per pin (gated clock) |
| cfg_bits | output | NUM_STRAPS | Latched strap values |
| cfg_valid | output | 1 | High from the cycle the strap latch becomes valid |
| spread_on | output | 1 | Spreading active |
| spread_wide | output | 1 | Modulation width selection from the strap |

## Verification
Two events can fall in the same cycle. The first is the window's last edge, on which the strap is latched. The second is a change of `pin_in` or a loss of `supply_good` close to that edge. The bench drops the supply ten cycles into a window and confirms that the full window is counted again with the new pin value. It also flips the pins right after the latch and confirms that the captured bits do not move. To judge the handover of the clock, the bench holds `src_clk` high while the driver is enabled and expects `pad_do` to stay low until `src_clk` has passed through a low phase.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned DEFAULT_WINDOW = 28636;
  typedef enum logic {PH_COUNT = 1'b0, PH_DONE = 1'b1} win_phase_t;
endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer
  import strap_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = DEFAULT_WINDOW
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_edge,
  output logic expired
);
  localparam int unsigned CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  win_phase_t    phase_q;

  assign last_edge = (phase_q == PH_COUNT) && (cnt_q == LAST);
  assign expired   = (phase_q == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_COUNT;
    end else if (phase_q == PH_COUNT) begin
      if (cnt_q == LAST) phase_q <= PH_DONE;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);
endmodule

// File: rtl/strap_pin_sync.sv
module strap_pin_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/strap_capture_reg.sv
module strap_capture_reg #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] bits,
  output logic             valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits  <= '0;
      valid <= 1'b0;
    end else if (take && !valid) begin
      bits  <= din;
      valid <= 1'b1;
    end
  end

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (valid && $stable(bits)));
  p_take_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> valid);
endmodule

// File: rtl/clk_handover_gate.sv
module clk_handover_gate (
  input  logic src_clk,
  input  logic rst_n,
  input  logic enable_req,
  output logic gate_on,
  output logic clk_out
);
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b0;
    else        gate_on <= enable_req;
  end

  assign clk_out = src_clk & gate_on;
endmodule

// File: rtl/strap_pin_sequencer.sv
module strap_pin_sequencer
  import strap_pkg::*;
#(
  parameter int unsigned NUM_STRAPS    = 2,
  parameter int unsigned WINDOW_CYCLES = DEFAULT_WINDOW,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned WIDTH_SEL_BIT = 0
) (
  input  logic                  clk_ref,
  input  logic                  supply_good,
  input  logic [NUM_STRAPS-1:0] pin_in,
  input  logic                  src_clk,
  input  logic                  spread_ctl_n,
  output logic [NUM_STRAPS-1:0] pad_oe,
  output logic [NUM_STRAPS-1:0] pad_do,
  output logic [NUM_STRAPS-1:0] cfg_bits,
  output logic                  cfg_valid,
  output logic                  spread_on,
  output logic                  spread_wide
);
  logic                  last_edge, expired;
  logic [NUM_STRAPS-1:0] pin_sync;
  logic                  oe_q;
  logic                  gate_on, gated_clk;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk_ref), .rst_n(supply_good), .last_edge(last_edge), .expired(expired)
  );

  strap_pin_sync #(.WIDTH(NUM_STRAPS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(supply_good), .din(pin_in), .dout(pin_sync)
  );

  strap_capture_reg #(.WIDTH(NUM_STRAPS)) u_cap (
    .clk(clk_ref), .rst_n(supply_good), .take(last_edge),
    .din(pin_sync), .bits(cfg_bits), .valid(cfg_valid)
  );

  always_ff @(posedge clk_ref or negedge supply_good) begin
    if (!supply_good) oe_q <= 1'b0;
    else              oe_q <= cfg_valid && expired;
  end

  clk_handover_gate u_gate (
    .src_clk(src_clk), .rst_n(supply_good), .enable_req(oe_q),
    .gate_on(gate_on), .clk_out(gated_clk)
  );

  assign pad_oe      = {NUM_STRAPS{oe_q}};
  assign pad_do      = {NUM_STRAPS{gated_clk}};
  assign spread_on   = cfg_valid & ~spread_ctl_n;
  assign spread_wide = cfg_bits[WIDTH_SEL_BIT];

  p_oe_needs_cfg_r2: assert property (@(posedge clk_ref) disable iff (!supply_good)
    !cfg_valid |-> (pad_oe == '0));
  p_oe_after_valid_r4: assert property (@(posedge clk_ref) disable iff (!supply_good)
    $rose(cfg_valid) |=> (pad_oe == '1));
  p_oe_sticky_r4: assert property (@(posedge clk_ref) disable iff (!supply_good)
    pad_oe[0] |=> pad_oe[0]);
  p_quiet_without_oe_r5: assert property (@(posedge clk_ref) disable iff (!supply_good)
    !pad_oe[0] |-> (!gate_on && pad_do == '0));
endmodule

// File: tb/strap_pin_sequencer_tb_top.sv
module strap_pin_sequencer_tb_top;
  localparam int N   = 2;
  localparam int WIN = 40;

  logic         clk_ref = 1'b0;
  logic         supply_good = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic         src_clk = 1'b0;
  logic         spread_ctl_n = 1'b1;
  logic [N-1:0] pad_oe, pad_do, cfg_bits;
  logic         cfg_valid, spread_on, spread_wide;

  int tests = 0;
  int fails = 0;

  always #2 clk_ref = ~clk_ref;

  strap_pin_sequencer #(.NUM_STRAPS(N), .WINDOW_CYCLES(WIN)) dut_i (
    .clk_ref(clk_ref), .supply_good(supply_good), .pin_in(pin_in),
    .src_clk(src_clk), .spread_ctl_n(spread_ctl_n), .pad_oe(pad_oe),
    .pad_do(pad_do), .cfg_bits(cfg_bits), .cfg_valid(cfg_valid),
    .spread_on(spread_on), .spread_wide(spread_wide)
  );

  // {pin[1:0], spread_ctl_n, exp_bits[1:0], exp_spread_on, exp_wide}
  localparam logic [6:0] VEC [4] = '{
    7'b00_1_00_0_0,
    7'b01_0_01_1_1,
    7'b10_0_10_1_0,
    7'b11_1_11_0_1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_window(input logic [N-1:0] pv, input logic ctl,
                            input logic [N-1:0] eb, input logic es, input logic ew);
    @(negedge clk_ref);
    supply_good = 1'b0;
    pin_in = pv;
    spread_ctl_n = ctl;
    @(negedge clk_ref);
    chk("R7 reset valid", 32'(cfg_valid), 0);
    chk("R7 reset oe", 32'(pad_oe), 0);
    supply_good = 1'b1;
    repeat (WIN - 1) @(negedge clk_ref);
    chk("R1 valid low before last edge", 32'(cfg_valid), 0);
    chk("R2 oe low in window", 32'(pad_oe), 0);
    chk("R8 spread off before valid", 32'(spread_on), 0);
    @(negedge clk_ref);
    chk("R1 valid at last edge", 32'(cfg_valid), 1);
    chk("R3 captured bits", 32'(cfg_bits), 32'(eb));
    chk("R4 oe still low", 32'(pad_oe), 0);
    chk("R8 spread_on", 32'(spread_on), 32'(es));
    chk("R8 spread_wide", 32'(spread_wide), 32'(ew));
    @(negedge clk_ref);
    chk("R4 oe one edge later", 32'(pad_oe), 32'(2**N - 1));
    pin_in = ~pv;
    repeat (5) @(negedge clk_ref);
    chk("R6 bits sticky", 32'(cfg_bits), 32'(eb));
    chk("R6 valid sticky", 32'(cfg_valid), 1);
  endtask

  initial begin
    #1;
    chk("R7 initial valid", 32'(cfg_valid), 0);
    chk("R7 initial pad_do", 32'(pad_do), 0);
    for (int i = 0; i < 4; i++) begin
      logic [6:0] v;
      v = VEC[i];
      run_window(v[6:5], v[4], v[3:2], v[1], v[0]);
    end

    // R7: supply lost mid-window, full window counted again
    @(negedge clk_ref);
    supply_good = 1'b0;
    pin_in = 2'b01;
    @(negedge clk_ref);
    supply_good = 1'b1;
    repeat (10) @(negedge clk_ref);
    supply_good = 1'b0;
    pin_in = 2'b10;
    #1;
    chk("R7 drop clears valid", 32'(cfg_valid), 0);
    @(negedge clk_ref);
    supply_good = 1'b1;
    repeat (WIN - 1) @(negedge clk_ref);
    chk("R7 window restarted", 32'(cfg_valid), 0);
    @(negedge clk_ref);
    chk("R7 restart valid", 32'(cfg_valid), 1);
    chk("R3 restart bits", 32'(cfg_bits), 32'h2);

    // R5: driver enabled while src_clk high, no runt pulse
    src_clk = 1'b1;
    run_window(2'b11, 1'b0, 2'b11, 1'b1, 1'b1);
    chk("R5 no pulse while src high", 32'(pad_do), 0);
    src_clk = 1'b0;
    #1;
    chk("R5 low phase", 32'(pad_do), 0);
    #3;
    src_clk = 1'b1;
    #1;
    chk("R5 full pulse", 32'(pad_do), 32'h3);
    supply_good = 1'b0;
    #1;
    chk("R7 pad_do cleared", 32'(pad_do), 0);
    chk("R7 bits cleared", 32'(cfg_bits), 0);
    chk("R7 oe cleared", 32'(pad_oe), 0);
    src_clk = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #600000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule